// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block is the write-side command front end of a NOR-style flash controller model. It watches a stream of single-cycle write strobes, each with an address and a data word. It recognises instructions that must be preceded by a fixed two-write coded unlock prefix. When an instruction completes, the sequencer emits a one-cycle registered pulse to the array engine. There are pulses for returning to array reads, entering the identifier/protection-status read mode, programming one location, erasing the whole array, erasing a set of blocks, and suspending or resuming an erase.

Any write that breaks a sequence sends the interface back to array-read mode, and the `rd_reset_o` pulse reports this. The erase path has a second coded prefix before its confirm write. After a block-erase confirm, a collection window stays open for a parameterised number of cycles. Each further block-confirm write inside the window adds a block and restarts the window. The engine receives a 19-bit block mask together with the start pulse.

The engine reports activity on `busy_i`. The sequencer tracks the erase-suspended state itself, so it only accepts the writes that are legal while the engine is running or suspended. Both byte and word address modes are supported.

Top module: `flash_cmd_seq`

## Requirements
- R1: After `rst_i` or `hw_rst_i`, every pulse output is low, `erase_timer_o` is 0, any partial sequence is discarded and the suspended state is cleared, so a following 30h write is treated as a bad first write (`rd_reset_o`).
- R2: The unlock prefix is data AAh then data 55h, with only data bits 7:0 compared. In word mode the addresses are 555h then 2AAh, and address bits 11 and above are ignored.
- R3: A third write at the first unlock address (555h word, AAAh byte) with F0h pulses `rd_reset_o`, and with 90h it pulses `autosel_o`.
- R4: A third write of A0h arms program mode. The next write pulses `prog_o`, and `prog_addr_o`/`prog_data_o` carry that write's full address and 16-bit data.
- R5: The sequence prefix, 80h, AAh, 55h, then 10h at the first unlock address pulses `chip_erase_o`.
- R6: The same erase prefix closed by 30h at any address opens the block collection window. Each further 30h write adds the block holding its address and restarts the window. `blk_erase_o` pulses exactly ERASE_WIN cycles after the last 30h write. `blk_mask_o` has bit n set for each selected block n, using top-boot numbering. Word address bits 18:15 give block n for n = 0..14. Inside the top 32K words, bits 14:12 values 0–3 give block 15, 4 gives 16, 5 gives 17, and 6–7 give 18.
- R7: `erase_timer_o` is 0 while the window is open and becomes 1 when the window expires. A 30h write after expiry adds no block and produces no second `blk_erase_o`; it pulses `rd_reset_o` instead.
- R8: A wrong address or data in any coded write, an out-of-order write, or any write other than 30h during the collection window pulses `rd_reset_o`. The sequence restarts, and a cancelled window never produces `blk_erase_o`.
- R9: F0h as a first write at any address pulses `rd_reset_o`.
- R10: While `busy_i` is high, only B0h is accepted; it pulses `suspend_o` at any address and marks the erase suspended. All other writes produce no pulse and do not advance the sequence.
- R11: While suspended and not busy, 30h at any address as a first write pulses `resume_o` and clears the suspended state. A full program sequence is still accepted, but the 80h erase set-up write is rejected with `rd_reset_o`.
- R12: With `byte_mode_i` high, the unlock addresses are AAAh and 555h (bits 12 and above ignored). Block decoding uses the byte address shifted right by one.
- R13: Every pulse output is high for exactly one cycle, namely the cycle after the write is sampled on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-up reset |
| hw_rst_i | input | 1 | Synchronous active-high hardware reset request |
| byte_mode_i | input | 1 | 1 = byte addressing, 0 = word addressing |
| wr_en_i | input | 1 | Write strobe, one write per high cycle |
| wr_addr_i | input | ADDR_W (20) | Write address |
| wr_data_i | input | DATA_W (16) | Write data; commands use bits 7:0 |
| busy_i | input | 1 | Array engine is running an operation |
| rd_reset_o | output | 1 | Pulse: return to array read (command or abort) |
| autosel_o | output | 1 | Pulse: enter identifier/status read mode |
| prog_o | output | 1 | Pulse: start program |
| prog_addr_o | output | ADDR_W (20) | Program target address |
| prog_data_o | output | DATA_W (16) | Program data |
| chip_erase_o | output | 1 | Pulse: start full-array erase |
| blk_erase_o | output | 1 | Pulse: start block erase |
| blk_mask_o | output | 19 | Blocks selected for erase |
| suspend_o | output | 1 | Pulse: suspend erase |
| resume_o | output | 1 | Pulse: resume erase |
| erase_timer_o | output | 1 | Block-collection window has expired |

## Verification
The hardest state to reach from the ports is suspended-but-idle, because it needs an engine that is busy at the moment B0h arrives and then goes quiet. The bench plays the engine itself: it raises `busy_i`, pushes a full program sequence that must be ignored, sends B0h, and drops `busy_i`. Only then does it probe that state: it checks that erase set-up is refused, that a program still goes through, and that a single 30h resumes. The collection window is timed by counting cycles after the last added block, so that an off-by-one restart of the window shows up.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int NBLK    = 19;
  localparam int WADDR_W = 19;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_AUTOSEL = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ESETUP  = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_BLOCK   = 8'h30;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PROG,
    SQ_EKEY0,
    SQ_EKEY1,
    SQ_EKEY2
  } seq_t;
endpackage

// File: rtl/flash_code_match.sv
module flash_code_match #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_mode_i,
  output logic              key1_o,
  output logic              key2_o
);
  always_comb begin
    if (byte_mode_i) begin
      key1_o = (addr_i[11:0] == 12'hAAA);
      key2_o = (addr_i[11:0] == 12'h555);
    end else begin
      key1_o = (addr_i[10:0] == 11'h555);
      key2_o = (addr_i[10:0] == 11'h2AA);
    end
  end
endmodule

// File: rtl/flash_blk_decode.sv
module flash_blk_decode
  import flash_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [WADDR_W-1:0] waddr_i,
  output logic [NBLK-1:0]    blk_o
);
  localparam int MAIN_LSB = WADDR_W - 4;
  localparam int SUB_LSB  = MAIN_LSB - 3;

  logic [3:0] main_idx;
  logic [2:0] sub_idx;
  logic [4:0] idx;

  assign main_idx = waddr_i[WADDR_W-1:MAIN_LSB];
  assign sub_idx  = waddr_i[MAIN_LSB-1:SUB_LSB];

  generate
    if (TOP_BOOT) begin : g_top
      always_comb begin
        if (main_idx != 4'hF)    idx = {1'b0, main_idx};
        else if (sub_idx < 3'd4) idx = 5'd15;
        else if (sub_idx == 3'd4) idx = 5'd16;
        else if (sub_idx == 3'd5) idx = 5'd17;
        else                      idx = 5'd18;
      end
    end else begin : g_bottom
      always_comb begin
        if (main_idx != 4'h0)     idx = {1'b0, main_idx} + 5'd3;
        else if (sub_idx < 3'd2)  idx = 5'd0;
        else if (sub_idx == 3'd2) idx = 5'd1;
        else if (sub_idx == 3'd3) idx = 5'd2;
        else                      idx = 5'd3;
      end
    end
  endgenerate

  always_comb begin
    blk_o = {{(NBLK-1){1'b0}}, 1'b1} << idx;
    AST_ONE_BLOCK: assert ($onehot(blk_o)); // R6
  end
endmodule

// File: rtl/flash_erase_window.sv
module flash_erase_window
  import flash_cmd_pkg::*;
#(
  parameter int ERASE_WIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_i,
  input  logic            add_i,
  input  logic            drop_i,
  input  logic [NBLK-1:0] blk_i,
  output logic            active_o,
  output logic            expire_o,
  output logic [NBLK-1:0] mask_o
);
  localparam int CNT_W = $clog2(ERASE_WIN + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(ERASE_WIN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic [NBLK-1:0]  mask_q;

  assign active_o = active_q;
  assign mask_o   = mask_q;
  assign expire_o = active_q && (cnt_q == '0) && !add_i && !drop_i && !start_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || drop_i) begin
      active_q <= 1'b0;
      mask_q   <= '0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      mask_q   <= blk_i;
      cnt_q    <= RELOAD;
    end else if (add_i && active_q) begin
      mask_q   <= mask_q | blk_i;
      cnt_q    <= RELOAD;
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_q <= 1'b0;
        mask_q   <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_EXPIRE_HAS_BLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
    expire_o |-> (mask_q != '0)); // R6
  AST_ADD_KEEPS_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (add_i && active_q && !drop_i) |=> active_q); // R6
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int ERASE_WIN = 16,
  parameter bit TOP_BOOT  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hw_rst_i,
  input  logic              byte_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              rd_reset_o,
  output logic              autosel_o,
  output logic              prog_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              chip_erase_o,
  output logic              blk_erase_o,
  output logic [NBLK-1:0]   blk_mask_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              erase_timer_o
);
  seq_t              state_q;
  logic              susp_q;
  logic              any_rst;
  logic [7:0]        cmd;
  logic              key1, key2;
  logic [WADDR_W-1:0] waddr;
  logic [NBLK-1:0]   blk_sel;
  logic              wr_ok;
  logic              win_start, win_add, win_drop;
  logic              win_active, win_expire;
  logic [NBLK-1:0]   win_mask;

  assign any_rst = rst_i || hw_rst_i;
  assign cmd     = wr_data_i[7:0];
  assign waddr   = byte_mode_i ? wr_addr_i[WADDR_W:1] : wr_addr_i[WADDR_W-1:0];
  assign wr_ok   = wr_en_i && !busy_i;

  assign win_start = wr_ok && !win_active && (state_q == SQ_EKEY2) && (cmd == CMD_BLOCK);
  assign win_add   = wr_ok && win_active && (cmd == CMD_BLOCK);
  assign win_drop  = wr_ok && win_active && (cmd != CMD_BLOCK);

  flash_code_match #(.ADDR_W(ADDR_W)) match_i (
    .addr_i      (wr_addr_i),
    .byte_mode_i (byte_mode_i),
    .key1_o      (key1),
    .key2_o      (key2)
  );

  flash_blk_decode #(.TOP_BOOT(TOP_BOOT)) decode_i (
    .waddr_i (waddr),
    .blk_o   (blk_sel)
  );

  flash_erase_window #(.ERASE_WIN(ERASE_WIN)) window_i (
    .clk_i    (clk_i),
    .rst_i    (any_rst),
    .start_i  (win_start),
    .add_i    (win_add),
    .drop_i   (win_drop),
    .blk_i    (blk_sel),
    .active_o (win_active),
    .expire_o (win_expire),
    .mask_o   (win_mask)
  );

  always_ff @(posedge clk_i) begin
    if (any_rst) begin
      state_q       <= SQ_IDLE;
      susp_q        <= 1'b0;
      rd_reset_o    <= 1'b0;
      autosel_o     <= 1'b0;
      prog_o        <= 1'b0;
      prog_addr_o   <= '0;
      prog_data_o   <= '0;
      chip_erase_o  <= 1'b0;
      blk_erase_o   <= 1'b0;
      blk_mask_o    <= '0;
      suspend_o     <= 1'b0;
      resume_o      <= 1'b0;
      erase_timer_o <= 1'b0;
    end else begin
      rd_reset_o   <= 1'b0;
      autosel_o    <= 1'b0;
      prog_o       <= 1'b0;
      chip_erase_o <= 1'b0;
      blk_erase_o  <= 1'b0;
      suspend_o    <= 1'b0;
      resume_o     <= 1'b0;

      if (win_expire) begin
        blk_erase_o   <= 1'b1;
        blk_mask_o    <= win_mask;
        erase_timer_o <= 1'b1;
      end

      if (wr_en_i && busy_i) begin
        if (!susp_q && cmd == CMD_SUSP) begin
          suspend_o <= 1'b1;
          susp_q    <= 1'b1;
        end
      end else if (wr_en_i && win_active) begin
        if (win_drop) rd_reset_o <= 1'b1;
      end else if (wr_en_i) begin
        state_q <= SQ_IDLE;
        case (state_q)
          SQ_IDLE: begin
            if (susp_q && cmd == CMD_RESUME) begin
              resume_o <= 1'b1;
              susp_q   <= 1'b0;
            end else if (cmd == CMD_KEY1 && key1) begin
              state_q <= SQ_KEY1;
            end else begin
              rd_reset_o <= 1'b1;
            end
          end
          SQ_KEY1: begin
            if (cmd == CMD_KEY2 && key2) state_q <= SQ_KEY2;
            else                         rd_reset_o <= 1'b1;
          end
          SQ_KEY2: begin
            if (!key1)                                 rd_reset_o <= 1'b1;
            else if (cmd == CMD_AUTOSEL)               autosel_o <= 1'b1;
            else if (cmd == CMD_PROG)                  state_q <= SQ_PROG;
            else if (cmd == CMD_ESETUP && !susp_q)     state_q <= SQ_EKEY0;
            else                                       rd_reset_o <= 1'b1;
          end
          SQ_PROG: begin
            prog_o      <= 1'b1;
            prog_addr_o <= wr_addr_i;
            prog_data_o <= wr_data_i;
          end
          SQ_EKEY0: begin
            if (cmd == CMD_KEY1 && key1) state_q <= SQ_EKEY1;
            else                         rd_reset_o <= 1'b1;
          end
          SQ_EKEY1: begin
            if (cmd == CMD_KEY2 && key2) state_q <= SQ_EKEY2;
            else                         rd_reset_o <= 1'b1;
          end
          SQ_EKEY2: begin
            if (cmd == CMD_CHIP && key1) chip_erase_o <= 1'b1;
            else if (cmd == CMD_BLOCK)   erase_timer_o <= 1'b0;
            else                         rd_reset_o <= 1'b1;
          end
          default: rd_reset_o <= 1'b1;
        endcase
      end
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (any_rst)
    $onehot0({rd_reset_o, autosel_o, prog_o, chip_erase_o, blk_erase_o, suspend_o, resume_o})); // R13
  AST_BUSY_GATES: assert property (@(posedge clk_i) disable iff (any_rst)
    (busy_i && wr_en_i) |=> !(prog_o || chip_erase_o || autosel_o || resume_o || rd_reset_o)); // R10
  AST_SUSP_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (any_rst)
    $rose(suspend_o) |-> $past(busy_i)); // R10
  AST_BLK_NONEMPTY: assert property (@(posedge clk_i) disable iff (any_rst)
    blk_erase_o |-> (blk_mask_o != '0)); // R6
  AST_TIMER_WITH_START: assert property (@(posedge clk_i) disable iff (any_rst)
    blk_erase_o |-> erase_timer_o); // R7
  AST_PROG_CAPTURE: assert property (@(posedge clk_i) disable iff (any_rst)
    $rose(prog_o) |-> (prog_addr_o == $past(wr_addr_i))); // R4
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int WIN = 16;

  logic        clk = 1'b0;
  logic        rst, hw_rst, byte_mode, wr_en, busy;
  logic [19:0] addr;
  logic [15:0] data;
  logic        rd_reset_o, autosel_o, prog_o, chip_erase_o, blk_erase_o;
  logic        suspend_o, resume_o, erase_timer_o;
  logic [19:0] prog_addr_o;
  logic [15:0] prog_data_o;
  logic [18:0] blk_mask_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [6:0] cap;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ERASE_WIN(WIN)) dut_i (
    .clk_i(clk), .rst_i(rst), .hw_rst_i(hw_rst), .byte_mode_i(byte_mode),
    .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(data), .busy_i(busy),
    .rd_reset_o(rd_reset_o), .autosel_o(autosel_o), .prog_o(prog_o),
    .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
    .chip_erase_o(chip_erase_o), .blk_erase_o(blk_erase_o), .blk_mask_o(blk_mask_o),
    .suspend_o(suspend_o), .resume_o(resume_o), .erase_timer_o(erase_timer_o));

  // pulse vector order: rd_reset, autosel, prog, chip, blk, suspend, resume
  localparam logic [6:0] P_RD = 7'b1000000, P_AS = 7'b0100000, P_PG = 7'b0010000,
                         P_CE = 7'b0001000, P_BE = 7'b0000100, P_SU = 7'b0000010,
                         P_RS = 7'b0000001, P_NONE = 7'b0;

  function automatic logic [6:0] pulses();
    return {rd_reset_o, autosel_o, prog_o, chip_erase_o, blk_erase_o, suspend_o, resume_o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0;
    cap = pulses();
  endtask

  task automatic unlock(input bit bm);
    if (bm) begin wr(20'h00AAA, 16'h00AA); wr(20'h00555, 16'h0055); end
    else    begin wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); end
  endtask

  task automatic t_reset();
    check("R1 pulses after reset", {25'd0, pulses()}, 32'(P_NONE));
    check("R1 timer after reset", {31'd0, erase_timer_o}, 32'd0);
  endtask

  task automatic t_read_reset();
    wr(20'h7F555, 16'hFFAA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00F0);
    check("R2 R3 high addr bits ignored, F0 third", {25'd0, cap}, 32'(P_RD));
    @(negedge clk);
    check("R13 pulse is one cycle", {25'd0, pulses()}, 32'(P_NONE));
    unlock(0); wr(20'h00555, 16'h0090);
    check("R3 autoselect", {25'd0, cap}, 32'(P_AS));
  endtask

  task automatic t_program();
    unlock(0); wr(20'h00555, 16'h00A0);
    check("R4 no pulse on set-up", {25'd0, cap}, 32'(P_NONE));
    wr(20'h12345, 16'hBEEF);
    check("R4 program pulse", {25'd0, cap}, 32'(P_PG));
    check("R4 program address", {12'd0, prog_addr_o}, 32'h12345);
    check("R4 program data", {16'd0, prog_data_o}, 32'hBEEF);
  endtask

  task automatic t_byte_mode();
    byte_mode = 1'b1;
    unlock(1); wr(20'h00AAA, 16'h00A0); wr(20'h00071, 16'h0042);
    check("R12 byte-mode program", {25'd0, cap}, 32'(P_PG));
    unlock(1); wr(20'h00AAA, 16'h0080); unlock(1); wr(20'h70000, 16'h0030);
    repeat (WIN + 2) @(negedge clk);
    check("R12 byte-mode block decode", {13'd0, blk_mask_o}, 32'h00080);
    byte_mode = 1'b0;
  endtask

  task automatic t_chip();
    unlock(0); wr(20'h00555, 16'h0080); unlock(0); wr(20'h00555, 16'h0010);
    check("R5 chip erase", {25'd0, cap}, 32'(P_CE));
  endtask

  task automatic t_block();
    int n = 0;
    unlock(0); wr(20'h00555, 16'h0080); unlock(0);
    wr(20'h7E000, 16'h0030);
    check("R7 timer low in window", {31'd0, erase_timer_o}, 32'd0);
    wr(20'h00000, 16'h0030);
    wr(20'h7C000, 16'h0030);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      if (blk_erase_o) break;
    end
    check("R6 start delay after last add", 32'(n), 32'(WIN));
    check("R6 block mask", {13'd0, blk_mask_o}, 32'h50001);
    check("R7 timer set on expiry", {31'd0, erase_timer_o}, 32'd1);
    wr(20'h38000, 16'h0030);
    check("R7 late add refused", {25'd0, cap}, 32'(P_RD));
    repeat (WIN + 2) @(negedge clk);
    check("R7 no second start", {13'd0, blk_mask_o}, 32'h50001);
  endtask

  task automatic t_window_cancel();
    bit seen = 0;
    unlock(0); wr(20'h00555, 16'h0080); unlock(0); wr(20'h38000, 16'h0030);
    wr(20'h00555, 16'h0055);
    check("R8 window cancel", {25'd0, cap}, 32'(P_RD));
    for (int i = 0; i < WIN + 4; i++) begin
      @(negedge clk);
      if (blk_erase_o) seen = 1;
    end
    check("R8 cancelled window no start", {31'd0, seen}, 32'd0);
  endtask

  task automatic t_abort();
    wr(20'h00555, 16'h00AA); wr(20'h00123, 16'h0055);
    check("R8 wrong second address", {25'd0, cap}, 32'(P_RD));
    wr(20'h002AA, 16'h0055);
    check("R8 out of order", {25'd0, cap}, 32'(P_RD));
    unlock(0); wr(20'h00555, 16'h0077);
    check("R8 bad command", {25'd0, cap}, 32'(P_RD));
    unlock(0); wr(20'h00555, 16'h0080); wr(20'h00555, 16'h00AB);
    check("R8 bad erase key", {25'd0, cap}, 32'(P_RD));
    wr(20'h12345, 16'h00F0);
    check("R9 F0 any address", {25'd0, cap}, 32'(P_RD));
  endtask

  task automatic t_busy_suspend();
    busy = 1'b1;
    wr(20'h00555, 16'h00AA);
    check("R10 busy ignores key", {25'd0, cap}, 32'(P_NONE));
    wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0); wr(20'h00100, 16'h1234);
    check("R10 busy ignores program", {25'd0, cap}, 32'(P_NONE));
    wr(20'h4A3C1, 16'h00B0);
    check("R10 suspend", {25'd0, cap}, 32'(P_SU));
    busy = 1'b0;
    wr(20'h00100, 16'h0034);
    check("R10 sequence not advanced", {25'd0, cap}, 32'(P_RD));
  endtask

  task automatic t_resume();
    unlock(0); wr(20'h00555, 16'h0080);
    check("R11 erase set-up refused", {25'd0, cap}, 32'(P_RD));
    unlock(0); wr(20'h00555, 16'h00A0); wr(20'h00200, 16'h5A5A);
    check("R11 program while suspended", {25'd0, cap}, 32'(P_PG));
    wr(20'h00100, 16'h0030);
    check("R11 resume", {25'd0, cap}, 32'(P_RS));
    wr(20'h00100, 16'h0030);
    check("R11 resume clears suspend", {25'd0, cap}, 32'(P_RD));
  endtask

  task automatic t_hw_reset();
    busy = 1'b1; wr(20'h00000, 16'h00B0); busy = 1'b0;
    unlock(0);
    @(negedge clk); hw_rst = 1'b1; @(negedge clk); hw_rst = 1'b0;
    check("R1 timer cleared by hw reset", {31'd0, erase_timer_o}, 32'd0);
    wr(20'h00000, 16'h0030);
    check("R1 suspend cleared by hw reset", {25'd0, cap}, 32'(P_RD));
    wr(20'h002AA, 16'h0055);
    check("R1 partial sequence dropped", {25'd0, cap}, 32'(P_RD));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hw_rst = 1'b0; byte_mode = 1'b0; wr_en = 1'b0; busy = 1'b0;
    addr = '0; data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_reset();
    t_program();
    t_chip();
    t_block();
    t_window_cancel();
    t_byte_mode();
    t_abort();
    t_busy_suspend();
    t_resume();
    t_hw_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule